// File: doc/BRIEF.md
# Byte-wide NOR flash command interface

This block is a synthesizable behavioural model of the command front end of a byte-wide parallel NOR flash. It has a byte array in on-chip memory and a bus with address, data in, data out, chip enable, write enable and output enable, all active low where they are enables. A write to the array is not a plain store. Each write is one step of a keyed unlock sequence. Only a complete sequence starts a byte program or a chip erase, or enters the identification mode.

Program and erase run as internal operations of fixed length. While one is running, a read returns status bits in place of array data, and commands written to the bus have no effect. Programming follows flash cell rules: it can only clear bits, and only a chip erase sets them back to 1. In identification mode, reads return a manufacturer code, a device code and per-sector protection flags. These come from parameters.

Top module: `flash_cmd_top`

## Requirements
- R1: A write is taken on the first clock where ce_n and we_n are both low after we_n was high. A read is active in every clock where ce_n and oe_n are low and we_n is high. dout is registered: in each such clock it loads the read value, and otherwise it loads 00h. An array read returns the stored byte.
- R2: A byte program is four writes: AAh to 555h, 55h to 2AAh, A0h to 555h, then data to the target. Unlock addresses compare the low 11 address bits. The stored byte becomes old data AND written data.
- R3: AAh to 555h, 55h to 2AAh, 90h to 555h enters identification mode. In that mode, low address byte 00h reads MFR_CODE, 01h reads DEV_CODE, 02h reads 01h if the sector in the top SECT_BITS address bits is protected (PROT_MASK bit) and 00h if not, and other offsets read 00h. The mode persists across any reads and any writes except F0h at any address, which returns to array read.
- R4: Chip erase is six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. Afterwards every byte reads FFh.
- R5: A write that does not match the expected step (address or data) returns the decoder to array-read mode. The sequence must then start again from the first unlock write.
- R6: Writes taken while a program or erase runs are ignored, including partial unlock sequences.
- R7: While busy, dout[7] is the complement of the written data bit 7 during a program and 0 during an erase. dout[6] inverts on each new read access.
- R8: While busy, dout[5] is 1 during a program whose data has a 1 in a bit position stored as 0, and 0 otherwise (always 0 in erase). dout[4:0] are 0.
- R9: A program keeps the block busy for PROG_CYCLES clocks after its last write, and an erase for one clock per byte. The block then returns to array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Registered read data or status |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |

## Verification
The assertions assume that we_n and oe_n are never low together, and that each write or read access is separated by at least one clock with the strobe high. Otherwise the edge detection would merge two accesses. The bench drives every access as a one-clock strobe followed by an idle clock, changes inputs only on the falling clock edge, and never overlaps reads and writes. It keeps its own model of the array to predict AND results and DQ5 flags. It sweeps all 256 data values across two passes over 256 addresses.

// File: rtl/flash_pkg.sv
// Shared types and command constants for the flash command interface.
// Assumes unlock addresses are compared on 11 low address bits.
package flash_pkg;

    localparam int LOW_W = 11;

    localparam logic [LOW_W-1:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [LOW_W-1:0] UNLOCK_ADDR_B = 11'h2AA;
    localparam logic [7:0] KEY_A      = 8'hAA;
    localparam logic [7:0] KEY_B      = 8'h55;
    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_ERASE   = 8'h80;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_RESET   = 8'hF0;

    typedef enum logic [2:0] {
        SQ_READ,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PGM_DATA,
        SQ_ERS_SET,
        SQ_ERS_KEY1,
        SQ_ERS_KEY2,
        SQ_IDENT
    } seq_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_PROGRAM,
        EN_ERASE
    } eng_t;

endpackage

// File: rtl/flash_bus_edges.sv
// Turns the asynchronous-style bus strobes into single-clock events.
// Assumes strobes are sampled on clk and each access lasts at least one clock.
module flash_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_stb,
    output logic rd_act,
    output logic rd_start
);

    logic we_n_q;
    logic rd_act_q;

    // Remember last write enable and read activity to find leading edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_n_q   <= 1'b1;
            rd_act_q <= 1'b0;
        end else begin
            we_n_q   <= we_n;
            rd_act_q <= rd_act;
        end
    end

    assign wr_stb   = !ce_n && !we_n && we_n_q;
    assign rd_act   = !ce_n && !oe_n && we_n;
    assign rd_start = rd_act && !rd_act_q;

endmodule

// File: rtl/flash_seq_decoder.sv
// Walks the keyed unlock sequences and issues program / erase starts.
// Assumes busy is high for the whole internal operation; writes are dropped then.
module flash_seq_decoder
    import flash_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             busy,
    input  logic [LOW_W-1:0] addr_low,
    input  logic [7:0]       din,
    output logic             prog_go,
    output logic             erase_go,
    output seq_t             seq_state
);

    seq_t nxt;
    logic at_a;
    logic at_b;
    logic take;

    assign at_a = (addr_low == UNLOCK_ADDR_A);
    assign at_b = (addr_low == UNLOCK_ADDR_B);
    assign take = wr_stb && !busy;

    // Next step of the sequence and the one-clock start pulses.
    always_comb begin
        nxt      = seq_state;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        if (take) begin
            case (seq_state)
                SQ_KEY1:     nxt = (at_b && din == KEY_B) ? SQ_KEY2 : SQ_READ;
                SQ_KEY2: begin
                    if (at_a && din == OP_PROGRAM)    nxt = SQ_PGM_DATA;
                    else if (at_a && din == OP_ERASE) nxt = SQ_ERS_SET;
                    else if (at_a && din == OP_IDENT) nxt = SQ_IDENT;
                    else                              nxt = SQ_READ;
                end
                SQ_PGM_DATA: begin
                    prog_go = 1'b1;
                    nxt     = SQ_READ;
                end
                SQ_ERS_SET:  nxt = (at_a && din == KEY_A) ? SQ_ERS_KEY1 : SQ_READ;
                SQ_ERS_KEY1: nxt = (at_b && din == KEY_B) ? SQ_ERS_KEY2 : SQ_READ;
                SQ_ERS_KEY2: begin
                    erase_go = at_a && din == OP_CHIP;
                    nxt      = SQ_READ;
                end
                SQ_IDENT:    nxt = (din == OP_RESET) ? SQ_READ : SQ_IDENT;
                default:     nxt = (at_a && din == KEY_A) ? SQ_KEY1 : SQ_READ;
            endcase
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_state <= SQ_READ;
        else        seq_state <= nxt;
    end

endmodule

// File: rtl/flash_engine.sv
// Array storage plus the internal program / erase operation and its status.
// Assumes go pulses only arrive while idle; memory content is not reset.
module flash_engine
    import flash_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic [7:0]        pg_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              erasing,
    output logic              st_bit7,
    output logic              st_fail,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [7:0]        mem [DEPTH];
    eng_t              state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] walk;
    logic [7:0]        old_byte;

    assign old_byte = mem[pg_addr];
    assign rd_data  = mem[rd_addr];
    assign busy     = (state != EN_IDLE);
    assign erasing  = (state == EN_ERASE);

    // Array write port: AND-program one byte or fill one byte per erase clock.
    always_ff @(posedge clk) begin
        if (prog_go && !busy)    mem[pg_addr] <= old_byte & pg_data;
        else if (state == EN_ERASE) mem[walk] <= 8'hFF;
    end

    // Operation sequencing, duration counting and captured status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= EN_IDLE;
            cnt     <= '0;
            walk    <= '0;
            st_bit7 <= 1'b0;
            st_fail <= 1'b0;
        end else begin
            case (state)
                EN_PROGRAM: begin
                    if (cnt == '0) state <= EN_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                EN_ERASE: begin
                    if (&walk) state <= EN_IDLE;
                    else       walk  <= walk + 1'b1;
                end
                default: begin
                    if (prog_go) begin
                        state   <= EN_PROGRAM;
                        cnt     <= CNT_W'(PROG_CYCLES - 1);
                        st_bit7 <= pg_data[7];
                        st_fail <= |(~old_byte & pg_data);
                    end else if (erase_go) begin
                        state   <= EN_ERASE;
                        walk    <= '0;
                        st_bit7 <= 1'b0;
                        st_fail <= 1'b0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_top.sv
// Top of the flash command interface: bus edge detection, sequence decoder,
// array engine and the registered read-data multiplexer.
// Assumes ADDR_W >= 11 so the unlock addresses fit, and SECT_BITS < ADDR_W.
module flash_cmd_top
    import flash_pkg::*;
#(
    parameter int                      ADDR_W      = 11,
    parameter int                      SECT_BITS   = 3,
    parameter int                      PROG_CYCLES = 16,
    parameter logic [7:0]              MFR_CODE    = 8'h37,
    parameter logic [7:0]              DEV_CODE    = 8'hA4,
    parameter logic [(1<<SECT_BITS)-1:0] PROT_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n
);

    logic                 wr_stb;
    logic                 rd_act;
    logic                 rd_start;
    logic                 prog_go;
    logic                 erase_go;
    seq_t                 seq_state;
    logic                 busy;
    logic                 erasing;
    logic                 st_bit7;
    logic                 st_fail;
    logic [7:0]           rd_data;
    logic                 tog;
    logic                 tog_nxt;
    logic [7:0]           rd_val;
    logic [SECT_BITS-1:0] sect;

    flash_bus_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_stb   (wr_stb),
        .rd_act   (rd_act),
        .rd_start (rd_start)
    );

    flash_seq_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .busy      (busy),
        .addr_low  (addr[LOW_W-1:0]),
        .din       (din),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .seq_state (seq_state)
    );

    flash_engine #(
        .ADDR_W      (ADDR_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_go  (prog_go),
        .erase_go (erase_go),
        .pg_addr  (addr),
        .pg_data  (din),
        .rd_addr  (addr),
        .busy     (busy),
        .erasing  (erasing),
        .st_bit7  (st_bit7),
        .st_fail  (st_fail),
        .rd_data  (rd_data)
    );

    assign sect    = addr[ADDR_W-1 -: SECT_BITS];
    assign tog_nxt = tog ^ rd_start;

    // Select status, identification data or array data for the current read.
    always_comb begin
        if (busy) begin
            rd_val = {~st_bit7 & ~erasing, tog_nxt, st_fail, 5'b0};
        end else if (seq_state == SQ_IDENT) begin
            case (addr[7:0])
                8'h00:   rd_val = MFR_CODE;
                8'h01:   rd_val = DEV_CODE;
                8'h02:   rd_val = {7'b0, PROT_MASK[sect]};
                default: rd_val = 8'h00;
            endcase
        end else begin
            rd_val = rd_data;
        end
    end

    // Toggle bit and registered data output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog  <= 1'b0;
            dout <= 8'h00;
        end else begin
            tog  <= tog_nxt;
            dout <= rd_act ? rd_val : 8'h00;
        end
    end

endmodule

// File: rtl/flash_cmd_checker.sv
// Temporal checks on the flash command interface, bound into the top.
// Assumes single-clock strobes separated by an idle clock (see brief).
module flash_cmd_checker
    import flash_pkg::*;
#(
    parameter int PROG_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       rd_act,
    input logic       busy,
    input logic       erasing,
    input logic       prog_go,
    input logic       erase_go,
    input seq_t       seq_state,
    input logic [7:0] din,
    input logic [7:0] dout
);

    int   len;
    logic last_prog;

    // Count busy clocks of the current operation and remember its kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len       <= 0;
            last_prog <= 1'b0;
        end else if (prog_go) begin
            len       <= 0;
            last_prog <= 1'b1;
        end else if (erase_go) begin
            len       <= 0;
            last_prog <= 1'b0;
        end else if (busy) begin
            len <= len + 1;
        end
    end

    AST_IDLE_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> dout == 8'h00); // R1

    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || erase_go) |-> !busy); // R2

    AST_IDENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_IDENT && !(wr_stb && din == OP_RESET)) |=> seq_state == SQ_IDENT); // R3

    AST_ERASE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> erasing); // R4

    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb) |=> $stable(seq_state)); // R6

    AST_ERASE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && erasing) |=> (dout[7] == 1'b0 && dout[5] == 1'b0)); // R7

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && busy) |=> dout[4:0] == 5'b0); // R8

    AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (last_prog && $fell(busy)) |-> len == PROG_CYCLES); // R9

    AST_PROG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> (busy && !erasing)); // R9

endmodule

bind flash_cmd_top flash_cmd_checker #(.PROG_CYCLES(PROG_CYCLES)) u_flash_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .rd_act    (rd_act),
    .busy      (busy),
    .erasing   (erasing),
    .prog_go   (prog_go),
    .erase_go  (erase_go),
    .seq_state (seq_state),
    .din       (din),
    .dout      (dout)
);

// File: tb/test_flash_cmd_top.sv
// Self-checking bench: sweeps program data over many addresses against a
// bench-side array model, and covers erase, identification, mismatches and
// writes during busy.
module test_flash_cmd_top;

    localparam int         ADDR_W  = 11;
    localparam int         SECT_B  = 3;
    localparam int         PCYC    = 6;
    localparam int         DEPTH   = 1 << ADDR_W;
    localparam logic [7:0] MFR     = 8'h37;
    localparam logic [7:0] DEV     = 8'hA4;
    localparam logic [7:0] PROT    = 8'b1010_0110;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              ce_n = 1'b1;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;

    int         total = 0;
    int         bad = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    flash_cmd_top #(
        .ADDR_W      (ADDR_W),
        .SECT_BITS   (SECT_B),
        .PROG_CYCLES (PCYC),
        .MFR_CODE    (MFR),
        .DEV_CODE    (DEV),
        .PROT_MASK   (PROT)
    ) i_flash_cmd_top (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .din   (din),
        .dout  (dout),
        .ce_n  (ce_n),
        .we_n  (we_n),
        .oe_n  (oe_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        v = dout;
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic unlock();
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
    endtask

    task automatic do_program(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        logic [7:0] s1, s2, rb;
        logic       fail;
        fail = |(~model[a] & d);
        unlock();
        bus_write(11'h555, 8'hA0);
        bus_write(a, d);
        bus_read(a, s1);
        bus_read(a, s2);
        check("R7 program dq7", {7'b0, s1[7]}, {7'b0, ~d[7]});
        check("R7 program dq6 toggles", {7'b0, s2[6]}, {7'b0, ~s1[6]});
        check("R8 program dq5", {7'b0, s1[5]}, {7'b0, fail});
        check("R8 status low bits", {3'b0, s1[4:0]}, 8'h00);
        model[a] = model[a] & d;
        repeat (PCYC + 2) @(negedge clk);
        bus_read(a, rb);
        check("R2 and-program readback", rb, model[a]);
    endtask

    task automatic do_erase();
        logic [7:0] s1, s2;
        unlock();
        bus_write(11'h555, 8'h80);
        unlock();
        bus_write(11'h555, 8'h10);
        bus_read(11'h0, s1);
        bus_read(11'h0, s2);
        check("R7 erase dq7", {7'b0, s1[7]}, 8'h00);
        check("R7 erase dq6 toggles", {7'b0, s2[6]}, {7'b0, ~s1[6]});
        check("R8 erase dq5 and low bits", {2'b0, s1[5:0]} & 8'h3F & ~8'h40, 8'h00);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    endtask

    task automatic verify_all(input string tag);
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(ADDR_W'(i), v);
            check(tag, v, model[i]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [ADDR_W-1:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: output is zero with no read active after reset
        check("R1 reset dout", dout, 8'h00);

        // R4: chip erase, then every byte reads FFh (R9: returns to array read)
        do_erase();
        repeat (DEPTH + 4) @(negedge clk);
        verify_all("R4 R9 erased array");

        // R2/R8: first pass, data i^5Ah onto erased bytes
        for (int i = 0; i < 256; i++) begin
            a = ADDR_W'((i * 7 + 3) % DEPTH);
            do_program(a, 8'(i) ^ 8'h5A);
        end
        // R2/R8: second pass, new data values ANDed in, DQ5 flags when set bits reappear
        for (int i = 0; i < 256; i++) begin
            a = ADDR_W'((i * 7 + 3) % DEPTH);
            do_program(a, 8'((i * 29 + 1) & 8'hFF));
        end
        // R1: plain array reads match model across whole array
        verify_all("R1 array read after programs");

        // R3: identification mode codes and protection per sector
        unlock();
        bus_write(11'h555, 8'h90);
        for (int s = 0; s < (1 << SECT_B); s++) begin
            bus_read(ADDR_W'((s << 8) | 2), v);
            check("R3 sector protect flag", v, {7'b0, PROT[s]});
            bus_read(ADDR_W'((s << 8) | 0), v);
            check("R3 manufacturer code", v, MFR);
            bus_read(ADDR_W'((s << 8) | 1), v);
            check("R3 device code", v, DEV);
            bus_read(ADDR_W'((s << 8) | 5), v);
            check("R3 other offset", v, 8'h00);
        end
        // R3: a non-reset write keeps the mode
        bus_write(11'h555, 8'hAA);
        bus_read(11'h100, v);
        check("R3 mode kept after other write", v, MFR);
        // R3: reset at any address exits to array read
        bus_write(11'h123, 8'hF0);
        bus_read(11'h3, v);
        check("R3 array read after reset", v, model[3]);

        // R5: wrong command address aborts
        a = 11'h7F0; model[a] = 8'hFF;
        do_erase();
        repeat (DEPTH + 4) @(negedge clk);
        unlock();
        bus_write(11'h554, 8'hA0);
        bus_write(a, 8'h00);
        bus_read(a, v);
        check("R5 wrong command address", v, 8'hFF);
        // R5: wrong second key aborts
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h54);
        bus_write(11'h555, 8'hA0);
        bus_write(a, 8'h00);
        bus_read(a, v);
        check("R5 wrong second key", v, 8'hFF);
        // R5: repeated first key restarts nothing; later steps are mismatches
        bus_write(11'h555, 8'hAA);
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, 8'hA0);
        bus_write(a, 8'h00);
        bus_read(a, v);
        check("R5 repeated first key", v, 8'hFF);
        // R5: bad erase confirm leaves array intact
        do_program(11'h010, 8'h3C);
        unlock();
        bus_write(11'h555, 8'h80);
        unlock();
        bus_write(11'h555, 8'h30);
        bus_read(11'h010, v);
        check("R5 bad erase confirm", v, 8'h3C);

        // R6: unlock writes during program busy are dropped
        unlock();
        bus_write(11'h555, 8'hA0);
        bus_write(11'h020, 8'hF0);
        model[11'h020] = model[11'h020] & 8'hF0;
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        repeat (PCYC + 2) @(negedge clk);
        bus_write(11'h555, 8'hA0);
        bus_write(11'h030, 8'h00);
        bus_read(11'h030, v);
        check("R6 unlock during program ignored", v, model[11'h030]);
        bus_read(11'h020, v);
        check("R2 program next to busy writes", v, model[11'h020]);
        // R6: full program sequence during erase is dropped
        do_erase();
        unlock();
        bus_write(11'h555, 8'hA0);
        bus_write(11'h040, 8'h00);
        repeat (DEPTH + 4) @(negedge clk);
        bus_read(11'h040, v);
        check("R6 program during erase ignored", v, 8'hFF);
        bus_read(11'h7FF, v);
        check("R4 last byte erased", v, 8'hFF);

        @(negedge clk);
        check("R1 idle dout at end", dout, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule